// File: doc/BRIEF.md
# Cartridge PRG/CHR Bank Register Decoder

This block is the register file and address translator of a cartridge memory mapper. It watches CPU writes to the upper half of the CPU address space and decodes them through a masked address. Only the top address nibble and the two lowest address bits choose a register. The registers it holds are two 8K program-ROM bank numbers, a swap-mode bit, a two-bit mirroring mode and eight 9-bit character-ROM page numbers.

From these registers it forms, without any clock delay, the program-ROM address for every CPU address and the character-ROM address for every PPU address. It also drives the select line that picks one of the two nametable pages in console video RAM. The upper 8K of program space always shows the last bank. A second fixed window shows the next-to-last bank, and the swap bit moves that window between the 8000 and C000 slots.

Each character page number is loaded in two writes, one for its low nibble and one for its upper five bits. The scanline interrupt registers (F000-F003) are outside this block, so writes there have no effect on it.

Top module: `cart_bank_mapper`

## Requirements
- R1: After a synchronous active-low reset, every register is zero. Program slot 8000 shows bank 0x00, A000 shows 0x00, C000 shows 0xFE and E000 shows 0xFF. All character pages are 0, and mirroring is vertical.
- R2: A write whose masked address (address AND 0xF00F) is 0x8000 loads data[7:0] as the bank of the swappable slot. With swap clear, that slot is 8000-9FFF.
- R3: A write with masked address 0xA000 loads data[7:0] as the bank shown at A000-BFFF.
- R4: A write with masked address 0x9002 sets the swap bit from data[1]. With swap set, C000-DFFF shows the 0x8000 register and 8000-9FFF shows bank 0xFE. With swap clear, this is reversed. Data bit 0 has no effect.
- R5: CPU addresses E000-FFFF always map to bank 0xFF, whatever has been written.
- R6: A write with masked address 0x9000 sets the mirroring mode from data[1:0]. The nametable select output is then PPU A10 for mode 0, PPU A11 for mode 1, 0 for mode 2 and 1 for mode 3.
- R7: Masked addresses B000-E003 address the character registers. The page index is 2×(top nibble − 0xB) plus address bit 1. Page i serves PPU addresses i×0x400 to i×0x400+0x3FF.
- R8: A character write with address bit 0 clear sets page bits [3:0] from data[3:0]. A write with address bit 0 set sets bits [8:4] from data[4:0]. The other part of the page number is kept in both cases.
- R9: Address bits 11:4 are ignored, so 0x8FF0 acts as 0x8000. Writes to masked addresses that are not registers have no effect on any output. This covers writes below 0x8000, 0x8004, 0x9001 and F000-F003.
- R10: A register changes only at a clock edge where the write strobe is high. With the strobe low, the outputs keep their values whatever the address and data.
- R11: The program address is {bank[7:0], CPU A[12:0]}. The character address is {page[8:0], PPU A[9:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address, used for write decode and program translation |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | Write strobe, sampled at the rising edge |
| ppu_addr | input | 13 | PPU address bits 12:0 |
| prg_addr | output | 21 | Program-ROM byte address |
| chr_addr | output | 19 | Character-ROM byte address |
| ciram_a10 | output | 1 | Nametable page select for console video RAM |

## Verification
The bench loads distinct values into all eight character registers, and into the high and low halves separately. An index decode that swaps address bit 1 with the nibble, or a half write that clears the other half, would return the wrong page. The swap bit is set and cleared with data bit 0 toggled against it, so a design that uses the wrong data bit, or that fails to move the next-to-last bank, would put the wrong bank in the 8000 or C000 slot. The tests write to aliased, non-register and interrupt addresses, and present writes with the strobe low. A loose decode would then corrupt a bank or the mirroring mode, and the corruption would show on the outputs. All four mirroring modes are checked on all four nametable quadrants.

// File: rtl/cart_bank_pkg.sv
// Shared widths and types for the cartridge bank mapper.
// Assumes 8K program pages and 1K character pages.
package cart_bank_pkg;
    localparam int PRG_BANK_W = 8;
    localparam int PRG_PAGE_W = 13;
    localparam int CHR_BANK_W = 9;
    localparam int CHR_LO_W   = 4;
    localparam int CHR_PAGE_W = 10;
    localparam int CHR_SLOTS  = 8;
    localparam int CPU_AW     = 16;
    localparam int PPU_AW     = 13;

    typedef enum logic [1:0] {
        MIR_VERT   = 2'd0,
        MIR_HORZ   = 2'd1,
        MIR_PAGE0  = 2'd2,
        MIR_PAGE1  = 2'd3
    } mirror_e;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_PRG_SW,
        WR_PRG_MID,
        WR_MIRROR,
        WR_SWAP,
        WR_CHR
    } wr_kind_e;
endpackage

// File: rtl/cart_wr_decode.sv
// Write decoder: classifies a CPU write by its address ANDed with 0xF00F.
// Assumes the strobe is already qualified by the caller's clock; purely combinational.
module cart_wr_decode
    import cart_bank_pkg::*;
#(
    parameter int SLOTS = CHR_SLOTS,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    output wr_kind_e          kind,
    output logic [IDX_W-1:0]  chr_idx,
    output logic              chr_hi
);
    logic [CPU_AW-1:0] masked;
    logic [3:0]        nib_off;

    assign masked  = cpu_addr & 16'hF00F;
    assign nib_off = masked[15:12] - 4'hB;
    assign chr_idx = {nib_off[IDX_W-2:0], masked[1]};
    assign chr_hi  = masked[0];

    // Pick the register addressed by this write, if any.
    always_comb begin
        kind = WR_NONE;
        if (cpu_wr) begin
            unique case (masked)
                16'h8000: kind = WR_PRG_SW;
                16'h9000: kind = WR_MIRROR;
                16'h9002: kind = WR_SWAP;
                16'hA000: kind = WR_PRG_MID;
                default: begin
                    if (masked[15:12] >= 4'hB && masked[15:12] <= 4'hE && masked[3:2] == 2'b00)
                        kind = WR_CHR;
                end
            endcase
        end
    end
endmodule

// File: rtl/cart_bank_regs.sv
// Bank register file: holds both program banks, the swap bit, the mirroring
// mode and the character pages. Assumes decoded write kinds from cart_wr_decode.
module cart_bank_regs
    import cart_bank_pkg::*;
#(
    parameter int SLOTS = CHR_SLOTS,
    parameter int PBW   = PRG_BANK_W,
    parameter int CBW   = CHR_BANK_W,
    parameter int LOW   = CHR_LO_W,
    localparam int IDX_W = $clog2(SLOTS),
    localparam int HIW   = CBW - LOW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  wr_kind_e                  kind,
    input  logic [IDX_W-1:0]          chr_idx,
    input  logic                      chr_hi,
    input  logic [7:0]                data,
    output logic [PBW-1:0]            prg_sw_q,
    output logic [PBW-1:0]            prg_mid_q,
    output logic                      swap_q,
    output mirror_e                   mirror_q,
    output logic [SLOTS-1:0][CBW-1:0] chr_q
);
    logic [SLOTS*HIW-1:0] hi_all;
    logic [SLOTS*LOW-1:0] lo_all;

    // Program banks, swap bit and mirroring mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_sw_q  <= '0;
            prg_mid_q <= '0;
            swap_q    <= 1'b0;
            mirror_q  <= MIR_VERT;
        end else begin
            case (kind)
                WR_PRG_SW:  prg_sw_q  <= data[PBW-1:0];
                WR_PRG_MID: prg_mid_q <= data[PBW-1:0];
                WR_SWAP:    swap_q    <= data[1];
                WR_MIRROR:  mirror_q  <= mirror_e'(data[1:0]);
                default: ;
            endcase
        end
    end

    for (genvar s = 0; s < SLOTS; s++) begin : g_chr
        // One character page, loaded a half at a time.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chr_q[s] <= '0;
            end else if (kind == WR_CHR && chr_idx == IDX_W'(s)) begin
                if (chr_hi) chr_q[s][CBW-1:LOW] <= data[HIW-1:0];
                else        chr_q[s][LOW-1:0]   <= data[LOW-1:0];
            end
        end
        assign hi_all[s*HIW +: HIW] = chr_q[s][CBW-1:LOW];
        assign lo_all[s*LOW +: LOW] = chr_q[s][LOW-1:0];
    end

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        kind == WR_NONE |=> $stable({prg_sw_q, prg_mid_q, swap_q, mirror_q, hi_all, lo_all}));

    assert_lo_keeps_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_CHR && !chr_hi) |=> $stable(hi_all));

    assert_hi_keeps_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_CHR && chr_hi) |=> $stable(lo_all));
endmodule

// File: rtl/cart_prg_xlate.sv
// Program translation: maps CPU A[14:13] to a bank and appends A[12:0].
// Assumes the last two banks are the top two values of the bank width.
module cart_prg_xlate
    import cart_bank_pkg::*;
#(
    parameter int PBW = PRG_BANK_W,
    parameter int PGW = PRG_PAGE_W,
    localparam logic [PBW-1:0] LAST_BANK = '1,
    localparam logic [PBW-1:0] PREV_BANK = LAST_BANK - 1'b1
) (
    input  logic [PGW+1:0]   cpu_addr,
    input  logic [PBW-1:0]   prg_sw,
    input  logic [PBW-1:0]   prg_mid,
    input  logic             swap,
    output logic [PBW+PGW-1:0] prg_addr
);
    logic [PBW-1:0] bank;

    // Select the bank for the 8K slot being read.
    always_comb begin
        unique case (cpu_addr[PGW+1:PGW])
            2'd0:    bank = swap ? PREV_BANK : prg_sw;
            2'd1:    bank = prg_mid;
            2'd2:    bank = swap ? prg_sw : PREV_BANK;
            default: bank = LAST_BANK;
        endcase
    end

    assign prg_addr = {bank, cpu_addr[PGW-1:0]};
endmodule

// File: rtl/cart_chr_xlate.sv
// Character translation and nametable select.
// Assumes 1K pages, in order across the PPU pattern space.
module cart_chr_xlate
    import cart_bank_pkg::*;
#(
    parameter int SLOTS = CHR_SLOTS,
    parameter int CBW   = CHR_BANK_W,
    parameter int PGW   = CHR_PAGE_W,
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic [PGW+IDX_W-1:0]      ppu_addr,
    input  logic [SLOTS-1:0][CBW-1:0] chr_banks,
    input  mirror_e                   mirror,
    output logic [CBW+PGW-1:0]        chr_addr,
    output logic                      ciram_a10
);
    logic [IDX_W-1:0] slot;

    assign slot     = ppu_addr[PGW+IDX_W-1:PGW];
    assign chr_addr = {chr_banks[slot], ppu_addr[PGW-1:0]};

    // Choose the nametable page line from the mirroring mode.
    always_comb begin
        unique case (mirror)
            MIR_VERT:  ciram_a10 = ppu_addr[10];
            MIR_HORZ:  ciram_a10 = ppu_addr[11];
            MIR_PAGE0: ciram_a10 = 1'b0;
            default:   ciram_a10 = 1'b1;
        endcase
    end
endmodule

// File: rtl/cart_bank_mapper.sv
// Top of the cartridge bank mapper: write decode, register file and
// both address translators. Assumes a single-cycle write strobe per access.
module cart_bank_mapper
    import cart_bank_pkg::*;
#(
    parameter int PBW = PRG_BANK_W,
    parameter int CBW = CHR_BANK_W,
    localparam int PRG_AW = PBW + PRG_PAGE_W,
    localparam int CHR_AW = CBW + CHR_PAGE_W,
    localparam int IDX_W  = $clog2(CHR_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [7:0]        cpu_data,
    input  logic              cpu_wr,
    input  logic [PPU_AW-1:0] ppu_addr,
    output logic [PRG_AW-1:0] prg_addr,
    output logic [CHR_AW-1:0] chr_addr,
    output logic              ciram_a10
);
    wr_kind_e                     kind;
    logic [IDX_W-1:0]             chr_idx;
    logic                         chr_hi;
    logic [PBW-1:0]               prg_sw_q;
    logic [PBW-1:0]               prg_mid_q;
    logic                         swap_q;
    mirror_e                      mirror_q;
    logic [CHR_SLOTS-1:0][CBW-1:0] chr_q;

    cart_wr_decode #(.SLOTS(CHR_SLOTS)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_wr   (cpu_wr),
        .kind     (kind),
        .chr_idx  (chr_idx),
        .chr_hi   (chr_hi)
    );

    cart_bank_regs #(.SLOTS(CHR_SLOTS), .PBW(PBW), .CBW(CBW), .LOW(CHR_LO_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .kind      (kind),
        .chr_idx   (chr_idx),
        .chr_hi    (chr_hi),
        .data      (cpu_data),
        .prg_sw_q  (prg_sw_q),
        .prg_mid_q (prg_mid_q),
        .swap_q    (swap_q),
        .mirror_q  (mirror_q),
        .chr_q     (chr_q)
    );

    cart_prg_xlate #(.PBW(PBW), .PGW(PRG_PAGE_W)) u_prg (
        .cpu_addr (cpu_addr[PRG_PAGE_W+1:0]),
        .prg_sw   (prg_sw_q),
        .prg_mid  (prg_mid_q),
        .swap     (swap_q),
        .prg_addr (prg_addr)
    );

    cart_chr_xlate #(.SLOTS(CHR_SLOTS), .CBW(CBW), .PGW(CHR_PAGE_W)) u_chr (
        .ppu_addr  (ppu_addr),
        .chr_banks (chr_q),
        .mirror    (mirror_q),
        .chr_addr  (chr_addr),
        .ciram_a10 (ciram_a10)
    );

    assert_fixed_top_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[14:13] == 2'b11 |-> prg_addr[PRG_AW-1:PRG_PAGE_W] == {PBW{1'b1}});

    assert_swap_moves_prev_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr & 16'hF00F) == 16'h9002 && cpu_data[1])
        |=> (cpu_addr[14:13] != 2'b00 || prg_addr[PRG_AW-1:PRG_PAGE_W] == {{(PBW-1){1'b1}}, 1'b0}));

    assert_one_screen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && (cpu_addr & 16'hF00F) == 16'h9000 && cpu_data[1])
        |=> ciram_a10 == $past(cpu_data[0]));
endmodule

// File: tb/cart_bank_mapper_bench.sv
`timescale 1ns/1ps
module cart_bank_mapper_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;
    logic [12:0] ppu_addr = '0;
    logic [20:0] prg_addr;
    logic [18:0] chr_addr;
    logic        ciram_a10;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    cart_bank_mapper u_cart_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_addr(prg_addr),
        .chr_addr(chr_addr), .ciram_a10(ciram_a10)
    );

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic chk_prg(input logic [15:0] a, input logic [7:0] bank, input string req);
        logic [20:0] exp;
        cpu_addr = a; #1;
        exp = {bank, a[12:0]};
        n_checks++;
        if (prg_addr !== exp) begin
            n_fail++;
            $display("FAIL %s prg @%h: got %h expected %h", req, a, prg_addr, exp);
        end
    endtask

    task automatic chk_chr(input logic [12:0] p, input logic [8:0] page, input string req);
        logic [18:0] exp;
        ppu_addr = p; #1;
        exp = {page, p[9:0]};
        n_checks++;
        if (chr_addr !== exp) begin
            n_fail++;
            $display("FAIL %s chr @%h: got %h expected %h", req, p, chr_addr, exp);
        end
    endtask

    task automatic chk_a10(input logic [12:0] p, input logic e, input string req);
        ppu_addr = p; #1;
        n_checks++;
        if (ciram_a10 !== e) begin
            n_fail++;
            $display("FAIL %s a10 @%h: got %b expected %b", req, p, ciram_a10, e);
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    // R1: reset state
    task automatic t_reset;
        chk_prg(16'h8123, 8'h00, "R1");
        chk_prg(16'hA000, 8'h00, "R1");
        chk_prg(16'hC456, 8'hFE, "R1");
        chk_prg(16'hFFFC, 8'hFF, "R1");
        chk_chr(13'h1FFF, 9'h000, "R1");
        chk_a10(13'h0400, 1'b1, "R1");
        chk_a10(13'h0800, 1'b0, "R1");
    endtask

    // R2, R3, R11: bank loads and address concatenation
    task automatic t_prg_basic;
        wr(16'h8000, 8'h12);
        wr(16'hA000, 8'h34);
        chk_prg(16'h9ABC, 8'h12, "R2");
        chk_prg(16'hA001, 8'h34, "R3");
        chk_prg(16'hBFFF, 8'h34, "R11");
        chk_prg(16'hC000, 8'hFE, "R2");
    endtask

    // R5: top window fixed
    task automatic t_fixed;
        wr(16'hA000, 8'hFE);
        chk_prg(16'hE000, 8'hFF, "R5");
        wr(16'hA000, 8'h34);
        chk_prg(16'hF123, 8'hFF, "R5");
    endtask

    // R4: swap bit on data[1] only
    task automatic t_swap;
        wr(16'h9002, 8'h02);
        chk_prg(16'h8000, 8'hFE, "R4");
        chk_prg(16'hC010, 8'h12, "R4");
        chk_prg(16'hA000, 8'h34, "R4");
        wr(16'h9002, 8'h01);
        chk_prg(16'h8000, 8'h12, "R4");
        chk_prg(16'hDFFF, 8'hFE, "R4");
        chk_a10(13'h0400, 1'b1, "R4");
    endtask

    // R6: all mirroring modes on all quadrants
    task automatic t_mirror;
        logic [1:0] m;
        for (int k = 0; k < 4; k++) begin
            m = 2'(k);
            wr(16'h9000, {6'b111111, m});
            for (int q = 0; q < 4; q++) begin
                logic e;
                case (m)
                    2'd0: e = q[0];
                    2'd1: e = q[1];
                    2'd2: e = 1'b0;
                    default: e = 1'b1;
                endcase
                chk_a10(13'(q * 16'h400 + 16'h15), e, "R6");
            end
        end
    endtask

    // R7: index decode over all eight pages
    task automatic t_chr_index;
        logic [15:0] base;
        for (int i = 0; i < 8; i++) begin
            base = 16'((16'hB + i / 2) << 12) | 16'((i % 2) * 2);
            wr(base, 8'(i + 1));
            wr(base | 16'h1, 8'(i + 3));
        end
        for (int i = 0; i < 8; i++) begin
            logic [8:0] e;
            e = {5'(i + 3), 4'(i + 1)};
            chk_chr(13'(i * 16'h400 + 16'h2A), e, "R7");
        end
    endtask

    // R8: halves kept independent, excess data bits dropped
    task automatic t_chr_halves;
        wr(16'hE003, 8'hFF);
        chk_chr(13'h1C00, 9'h1F8, "R8");
        wr(16'hE002, 8'hF5);
        chk_chr(13'h1FFF, 9'h1F5, "R8");
        chk_chr(13'h1800, {5'd9, 4'd7}, "R8");
    endtask

    // R9: aliasing and non-register addresses
    task automatic t_mask;
        wr(16'h8FF0, 8'h33);
        chk_prg(16'h8000, 8'h33, "R9");
        wr(16'h8004, 8'h44);
        wr(16'h0000, 8'h55);
        wr(16'h7000, 8'h66);
        chk_prg(16'h8000, 8'h33, "R9");
        wr(16'h9001, 8'h00);
        chk_a10(13'h0000, 1'b1, "R9");
        for (int j = 0; j < 4; j++) wr(16'hF000 + 16'(j), 8'h00);
        wr(16'hB004, 8'h00);
        chk_chr(13'h1C00, 9'h1F5, "R9");
        chk_chr(13'h0000, {5'd3, 4'd1}, "R9");
        chk_prg(16'hA000, 8'h34, "R9");
    endtask

    // R10: strobe low changes nothing
    task automatic t_idle;
        @(negedge clk);
        cpu_addr = 16'hA000; cpu_data = 8'h77; cpu_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk_prg(16'hA000, 8'h34, "R10");
        cpu_addr = 16'h9000; cpu_data = 8'h00;
        repeat (2) @(negedge clk);
        chk_a10(13'h0000, 1'b1, "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_prg_basic();
        t_fixed();
        t_swap();
        t_chr_index();
        t_chr_halves();
        t_mirror();
        t_mask();
        t_idle();
        report();
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end
endmodule